// File: doc/BRIEF.md
# Truth-Table Quadrature Step Counter

This block turns the two phase signals of an incremental rotary encoder into a signed position count. Both phases are first brought into the clock domain by a two-stage synchronizer. Four small logic cells then do the decoding. Each cell looks up one bit of a fixed 16-entry table and feeds it through its own glitch filter, which has separate programmable delays for rising and falling changes. Two of the cells pass the filtered A and B levels through. Registered copies of those levels, taken one clock later, give the "previous" sample. The other two cells look at the current and previous levels and fire a one-clock step pulse. One of them fires on forward (clockwise) transitions and the other on reverse transitions.

There is no direction state machine. Each step stream drives its own up-counter, and each counter has an overflow extension. Both counters leave reset holding 1. The signed difference of the two extended totals is formed only when the position is read. A one-cycle capture request freezes the position and both raw counts together. A valid pulse follows, so a consumer always reads a consistent set. If both phases change in the same sample, the movement cannot be decoded. In that case neither counter moves and a sticky error flag is set.

Top module: `quad_lut_counter`

## Requirements
- R1: A change on a phase pin shows up on its filtered level output exactly 3 + d clock edges after the pin changes, where d is that cell's rise delay (for a 0 to 1 change) or fall delay (for a 1 to 0 change). Cell 0 carries phase A and uses bits [FILT_W-1:0] of the delay buses. Cell 1 carries phase B and uses the next FILT_W bits.
- R2: A change on a synchronized phase that holds for d samples or fewer, before returning, never reaches the filtered level. The position is not affected either.
- R3: The lookup index is {B_prev, A_prev, B, A}, with bit 0 = A. The forward cell uses table 0x4182, which is true at indices 1, 7, 8 and 14. So the (A,B) sequence 00→10→11→01→00 adds one to the forward count per transition.
- R4: The reverse cell uses table 0x2814, which is true at indices 2, 4, 11 and 13. So the sequence 00→01→11→10→00 adds one to the reverse count per transition.
- R5: A sample in which A and B both change produces no step pulse. It sets seqError, which stays set until reset.
- R6: After reset, both raw counts hold 1, the position reads 0, and seqError and capValid are 0.
- R7: A counter that steps while at countMax becomes 0 instead, and its overflow extension increases by one.
- R8: The captured position equals (fwd + countMax·fwdOvf) − (rev + countMax·revOvf), truncated to 32-bit two's complement.
- R9: When capture is high at clock edge c, the snapshot is taken at edge c+1. capValid is then high for the one cycle after edge c+2.
- R10: Cells 2 and 3 take per-cell delays on the same buses, in slots 2 and 3. With those delays at 0, every legal transition yields a step pulse exactly one cycle wide.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| encA | input | 1 | Encoder phase A pin (asynchronous) |
| encB | input | 1 | Encoder phase B pin (asynchronous) |
| riseDly | input | 4*FILT_W | Per-cell rise filter delay, cell i in slot i |
| fallDly | input | 4*FILT_W | Per-cell fall filter delay, cell i in slot i |
| countMax | input | CNT_W | Wrap value of both step counters |
| capture | input | 1 | Snapshot request |
| levelA | output | 1 | Filtered phase A |
| levelB | output | 1 | Filtered phase B |
| cwPulse | output | 1 | Forward step pulse |
| ccwPulse | output | 1 | Reverse step pulse |
| seqError | output | 1 | Sticky double-change flag |
| capValid | output | 1 | Snapshot ready pulse |
| capPos | output | POS_W | Captured signed position |
| capCw | output | CNT_W | Captured forward raw count |
| capCcw | output | CNT_W | Captured reverse raw count |

## Verification
The assertions assume three things about the inputs. The delay buses and countMax stay constant while out of reset. The step cells run with zero delay when a jump is checked. The capture request is a single-cycle strobe. The stimulus sets delays and countMax once, before reset is released, and never changes them. It raises capture for exactly one cycle. It moves the encoder only after the previous step has fully settled into the counters, and only while no capture is in flight, so every snapshot has a single expected value. The double-change case is produced on purpose by giving A and B equal delays and toggling both pins in the same cycle.

// File: rtl/qlc_pkg.sv
package qlc_pkg;
  localparam int NUM_CELLS = 4;
  localparam int CELL_A    = 0;
  localparam int CELL_B    = 1;
  localparam int CELL_FWD  = 2;
  localparam int CELL_REV  = 3;

  // Table per cell, element i belongs to cell i.
  localparam logic [NUM_CELLS-1:0][15:0] CELL_TABLES =
    {16'h2814, 16'h4182, 16'hCCCC, 16'hAAAA};

  typedef struct packed {
    logic fwdInc;
    logic revInc;
    logic latch;
  } qlcStrobe_t;
endpackage

// File: rtl/qlc_glitch_filter.sv
module qlc_glitch_filter #(
  parameter int FILT_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              din,
  input  logic [FILT_W-1:0] riseDly,
  input  logic [FILT_W-1:0] fallDly,
  output logic              dout
);
  logic [FILT_W-1:0] runLen;
  logic [FILT_W-1:0] curDly;

  assign curDly = din ? riseDly : fallDly;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      runLen <= '0;
      dout   <= 1'b0;
    end else if (din == dout) begin
      runLen <= '0;
    end else if (runLen >= curDly) begin
      dout   <= din;
      runLen <= '0;
    end else begin
      runLen <= runLen + 1'b1;
    end
  end

  // While the new value has not yet held long enough, the output must not move.
  p_filter_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (din != dout && runLen < curDly) |=> $stable(dout));

  // An input equal to the output never changes the output.
  p_filter_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (din == dout) |=> $stable(dout));
endmodule

// File: rtl/qlc_lut_cell.sv
module qlc_lut_cell #(
  parameter logic [15:0] TABLE  = 16'h0000,
  parameter int          FILT_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [3:0]        idx,
  input  logic [FILT_W-1:0] riseDly,
  input  logic [FILT_W-1:0] fallDly,
  output logic              dout
);
  logic lutOut;

  assign lutOut = TABLE[idx];

  qlc_glitch_filter #(.FILT_W(FILT_W)) uFilt (
    .clk     (clk),
    .rst_n   (rst_n),
    .din     (lutOut),
    .riseDly (riseDly),
    .fallDly (fallDly),
    .dout    (dout)
  );
endmodule

// File: rtl/qlc_ctrl.sv
module qlc_ctrl
  import qlc_pkg::*;
#(
  parameter int FILT_W = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        pinA,
  input  logic                        pinB,
  input  logic [NUM_CELLS*FILT_W-1:0] riseDly,
  input  logic [NUM_CELLS*FILT_W-1:0] fallDly,
  input  logic                        capture,
  output logic                        levelA,
  output logic                        levelB,
  output logic                        cwPulse,
  output logic                        ccwPulse,
  output logic                        seqError,
  output logic                        capValid,
  output qlcStrobe_t                  strobe
);
  logic [1:0] syncA, syncB;
  logic       prevA, prevB;
  logic [NUM_CELLS-1:0] cellOut;
  logic [3:0] rawIdx, filtIdx;
  logic       jump;
  logic       errQ;
  logic       capQ, capDone, validQ;

  // Two-stage synchronizers on the asynchronous pins.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      syncA <= '0;
      syncB <= '0;
    end else begin
      syncA <= {syncA[0], pinA};
      syncB <= {syncB[0], pinB};
    end
  end

  // Previous filtered levels, one clock behind.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prevA <= 1'b0;
      prevB <= 1'b0;
    end else begin
      prevA <= cellOut[CELL_A];
      prevB <= cellOut[CELL_B];
    end
  end

  assign rawIdx  = {prevB, prevA, syncB[1], syncA[1]};
  assign filtIdx = {prevB, prevA, cellOut[CELL_B], cellOut[CELL_A]};

  for (genvar g = 0; g < NUM_CELLS; g++) begin : gCell
    localparam logic [15:0] TBL = CELL_TABLES[g];
    logic [3:0] cellIdx;
    if (g < 2) begin : gLevel
      assign cellIdx = rawIdx;
    end else begin : gStep
      assign cellIdx = filtIdx;
    end
    qlc_lut_cell #(.TABLE(TBL), .FILT_W(FILT_W)) uCell (
      .clk     (clk),
      .rst_n   (rst_n),
      .idx     (cellIdx),
      .riseDly (riseDly[g*FILT_W +: FILT_W]),
      .fallDly (fallDly[g*FILT_W +: FILT_W]),
      .dout    (cellOut[g])
    );
  end

  // Both phases moving in one sample cannot be decoded.
  assign jump = (cellOut[CELL_A] ^ prevA) & (cellOut[CELL_B] ^ prevB);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) errQ <= 1'b0;
    else if (jump) errQ <= 1'b1;
  end

  // Capture sequencing: request, snapshot, valid.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      capQ    <= 1'b0;
      capDone <= 1'b0;
      validQ  <= 1'b0;
    end else begin
      capQ    <= capture;
      capDone <= capQ;
      validQ  <= capDone;
    end
  end

  assign levelA   = cellOut[CELL_A];
  assign levelB   = cellOut[CELL_B];
  assign cwPulse  = cellOut[CELL_FWD];
  assign ccwPulse = cellOut[CELL_REV];
  assign seqError = errQ;
  assign capValid = validQ;

  assign strobe.fwdInc = cellOut[CELL_FWD];
  assign strobe.revInc = cellOut[CELL_REV];
  assign strobe.latch  = capQ;

  p_err_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    seqError |=> seqError);

  p_no_step_on_jump_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (jump && riseDly[CELL_FWD*FILT_W +: FILT_W] == '0 &&
     riseDly[CELL_REV*FILT_W +: FILT_W] == '0) |=> (!cwPulse && !ccwPulse));

  p_cap_valid_r9: assert property (@(posedge clk) disable iff (!rst_n)
    capValid |-> $past(capture, 3));

  p_level_step_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cwPulse, ccwPulse}) || riseDly[CELL_FWD*FILT_W +: FILT_W] != '0
      || riseDly[CELL_REV*FILT_W +: FILT_W] != '0);
endmodule

// File: rtl/qlc_datapath.sv
module qlc_datapath
  import qlc_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int OVF_W = 16,
  parameter int POS_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] countMax,
  input  qlcStrobe_t       strobe,
  output logic [POS_W-1:0] capPos,
  output logic [CNT_W-1:0] capCw,
  output logic [CNT_W-1:0] capCcw
);
  localparam int NUM_DIR = 2;

  logic [NUM_DIR-1:0]  incVec;
  logic [CNT_W-1:0]    cnt [NUM_DIR];
  logic [OVF_W-1:0]    ovf [NUM_DIR];
  logic [POS_W-1:0]    total [NUM_DIR];
  logic [POS_W-1:0]    livePos;

  assign incVec = {strobe.revInc, strobe.fwdInc};

  for (genvar d = 0; d < NUM_DIR; d++) begin : gDir
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cnt[d] <= CNT_W'(1);
        ovf[d] <= '0;
      end else if (incVec[d]) begin
        if (cnt[d] == countMax) begin
          cnt[d] <= '0;
          ovf[d] <= ovf[d] + 1'b1;
        end else begin
          cnt[d] <= cnt[d] + 1'b1;
        end
      end
    end

    assign total[d] = POS_W'(cnt[d]) + POS_W'(countMax) * POS_W'(ovf[d]);

    p_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (incVec[d] && cnt[d] == countMax) |=>
        (cnt[d] == '0 && ovf[d] == $past(ovf[d]) + 1'b1));

    p_step_r3_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (incVec[d] && cnt[d] != countMax) |=>
        (cnt[d] == $past(cnt[d]) + 1'b1 && $stable(ovf[d])));

    p_idle_r3_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !incVec[d] |=> ($stable(cnt[d]) && $stable(ovf[d])));
  end

  assign livePos = total[0] - total[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      capPos <= '0;
      capCw  <= CNT_W'(1);
      capCcw <= CNT_W'(1);
    end else if (strobe.latch) begin
      capPos <= livePos;
      capCw  <= cnt[0];
      capCcw <= cnt[1];
    end
  end

  p_snap_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe.latch |=> ($stable(capPos) && $stable(capCw) && $stable(capCcw)));

  p_balanced_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.latch && cnt[0] == cnt[1] && ovf[0] == ovf[1]) |=> capPos == '0);
endmodule

// File: rtl/quad_lut_counter.sv
module quad_lut_counter
  import qlc_pkg::*;
#(
  parameter int FILT_W = 4,
  parameter int CNT_W  = 16,
  parameter int OVF_W  = 16,
  parameter int POS_W  = 32
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        encA,
  input  logic                        encB,
  input  logic [NUM_CELLS*FILT_W-1:0] riseDly,
  input  logic [NUM_CELLS*FILT_W-1:0] fallDly,
  input  logic [CNT_W-1:0]            countMax,
  input  logic                        capture,
  output logic                        levelA,
  output logic                        levelB,
  output logic                        cwPulse,
  output logic                        ccwPulse,
  output logic                        seqError,
  output logic                        capValid,
  output logic [POS_W-1:0]            capPos,
  output logic [CNT_W-1:0]            capCw,
  output logic [CNT_W-1:0]            capCcw
);
  qlcStrobe_t strobe;

  qlc_ctrl #(.FILT_W(FILT_W)) uCtrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .pinA     (encA),
    .pinB     (encB),
    .riseDly  (riseDly),
    .fallDly  (fallDly),
    .capture  (capture),
    .levelA   (levelA),
    .levelB   (levelB),
    .cwPulse  (cwPulse),
    .ccwPulse (ccwPulse),
    .seqError (seqError),
    .capValid (capValid),
    .strobe   (strobe)
  );

  qlc_datapath #(.CNT_W(CNT_W), .OVF_W(OVF_W), .POS_W(POS_W)) uData (
    .clk      (clk),
    .rst_n    (rst_n),
    .countMax (countMax),
    .strobe   (strobe),
    .capPos   (capPos),
    .capCw    (capCw),
    .capCcw   (capCcw)
  );
endmodule

// File: tb/quad_lut_counter_test.sv
`timescale 1ns/1ps
module quad_lut_counter_test;
  localparam int FILT_W = 4;
  localparam int CNT_W  = 16;
  localparam int POS_W  = 32;
  localparam int MAXV   = 5;
  localparam int SETTLE = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic encA = 1'b0, encB = 1'b0, capture = 1'b0;
  logic [4*FILT_W-1:0] riseDly, fallDly;
  logic [CNT_W-1:0] countMax;
  logic levelA, levelB, cwPulse, ccwPulse, seqError, capValid;
  logic [POS_W-1:0] capPos;
  logic [CNT_W-1:0] capCw, capCcw;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  // Bench model of the encoder and both counters.
  int ph = 0;
  int fwdC = 1, fwdO = 0, revC = 1, revO = 0;
  int pulseSeen = 0;

  logic [POS_W-1:0] qPos[$];
  int qCw[$];
  int qCcw[$];

  always #2.5 clk = ~clk;

  quad_lut_counter #(.FILT_W(FILT_W), .CNT_W(CNT_W), .POS_W(POS_W)) uut (
    .clk(clk), .rst_n(rst_n), .encA(encA), .encB(encB),
    .riseDly(riseDly), .fallDly(fallDly), .countMax(countMax),
    .capture(capture), .levelA(levelA), .levelB(levelB),
    .cwPulse(cwPulse), .ccwPulse(ccwPulse), .seqError(seqError),
    .capValid(capValid), .capPos(capPos), .capCw(capCw), .capCcw(capCcw)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic logic [POS_W-1:0] expPos();
    return POS_W'(fwdC + MAXV * fwdO) - POS_W'(revC + MAXV * revO);
  endfunction

  task automatic drivePhase();
    encA = (ph == 1 || ph == 2);
    encB = (ph == 2 || ph == 3);
  endtask

  task automatic stepFwd();  // R3
    @(negedge clk);
    ph = (ph + 1) % 4;
    drivePhase();
    if (fwdC == MAXV) begin fwdC = 0; fwdO++; end else fwdC++;
    repeat (SETTLE) @(posedge clk);
  endtask

  task automatic stepRev();  // R4
    @(negedge clk);
    ph = (ph + 3) % 4;
    drivePhase();
    if (revC == MAXV) begin revC = 0; revO++; end else revC++;
    repeat (SETTLE) @(posedge clk);
  endtask

  // Scoreboard driver: push expected snapshot, issue a one-cycle request.
  task automatic snap(input string req);
    qPos.push_back(expPos());
    qCw.push_back(fwdC);
    qCcw.push_back(revC);
    @(negedge clk);
    capture = 1'b1;
    @(posedge clk);            // edge c
    @(negedge clk);
    capture = 1'b0;
    check(capValid == 1'b0, "R9", "capValid early c", capValid, 0);
    @(posedge clk);            // edge c+1
    @(negedge clk);
    check(capValid == 1'b0, "R9", "capValid early c+1", capValid, 0);
    @(posedge clk);            // edge c+2
    @(negedge clk);
    check(capValid == 1'b1, "R9", {"capValid at c+2 ", req}, capValid, 1);
    @(posedge clk);
    @(negedge clk);
    check(capValid == 1'b0, "R9", "capValid one cycle", capValid, 0);
  endtask

  // Scoreboard monitor.
  always @(negedge clk) begin
    if (rst_n && capValid) begin
      if (qPos.size() == 0) begin
        check(1'b0, "R9", "unexpected capValid", 1, 0);
      end else begin
        automatic logic [POS_W-1:0] ep = qPos.pop_front();
        automatic int ec = qCw.pop_front();
        automatic int er = qCcw.pop_front();
        check(capPos == ep, "R8", "captured position",
              longint'($signed(capPos)), longint'($signed(ep)));
        check(capCw == CNT_W'(ec), "R7", "captured forward count", capCw, ec);
        check(capCcw == CNT_W'(er), "R7", "captured reverse count", capCcw, er);
      end
    end
  end

  // Pulse width monitor for R10.
  always @(negedge clk) begin
    if (rst_n && cwPulse) pulseSeen++;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    // Level cells: rise 2, fall 1; step cells: 0.
    riseDly  = {4'd0, 4'd0, 4'd2, 4'd2};
    fallDly  = {4'd0, 4'd0, 4'd1, 4'd1};
    countMax = CNT_W'(MAXV);
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);

    // R6 reset state
    check(levelA == 0 && levelB == 0, "R6", "levels after reset", {levelB, levelA}, 0);
    check(seqError == 0, "R6", "seqError after reset", seqError, 0);
    check(capValid == 0, "R6", "capValid after reset", capValid, 0);
    snap("R6");

    // R1 latency: A rises (forward step), rise delay 2 -> edge 5
    @(negedge clk);
    ph = 1; drivePhase();
    fwdC++;
    repeat (4) @(posedge clk);
    @(negedge clk);
    check(levelA == 0, "R1", "levelA before 3+rise", levelA, 0);
    pulseSeen = 0;
    @(posedge clk);
    @(negedge clk);
    check(levelA == 1, "R1", "levelA at 3+rise", levelA, 1);
    repeat (SETTLE) @(posedge clk);
    @(negedge clk);
    check(pulseSeen == 1, "R10", "forward pulse width", pulseSeen, 1);

    // R1 latency: A falls (reverse step), fall delay 1 -> edge 4
    ph = 0; drivePhase();
    revC++;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(levelA == 1, "R1", "levelA before 3+fall", levelA, 1);
    @(posedge clk);
    @(negedge clk);
    check(levelA == 0, "R1", "levelA at 3+fall", levelA, 0);
    repeat (SETTLE) @(posedge clk);
    snap("R1");

    // R2 glitch: A high for two cycles only
    @(negedge clk);
    encA = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    encA = 1'b0;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      check(levelA == 0, "R2", "glitch reached level", levelA, 0);
    end
    snap("R2");

    // R3 / R7 forward steps across two wraps
    for (int i = 0; i < 12; i++) stepFwd();
    snap("R3");

    // R4 reverse steps, position goes negative
    for (int i = 0; i < 23; i++) stepRev();
    snap("R4");

    // Mixed pattern
    for (int i = 0; i < 3; i++) begin stepFwd(); stepFwd(); stepRev(); end
    snap("R8");

    // R5 double change: both pins toggle together
    @(negedge clk);
    check(seqError == 0, "R5", "seqError before jump", seqError, 0);
    ph = (ph + 2) % 4;
    drivePhase();
    repeat (SETTLE) @(posedge clk);
    @(negedge clk);
    check(seqError == 1, "R5", "seqError after jump", seqError, 1);
    snap("R5");
    stepFwd();
    stepRev();
    @(negedge clk);
    check(seqError == 1, "R5", "seqError sticky", seqError, 1);
    snap("R5");

    // R5 / R6 reset clears everything
    @(negedge clk);
    rst_n = 1'b0;
    ph = 0; drivePhase();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    fwdC = 1; fwdO = 0; revC = 1; revO = 0;
    repeat (SETTLE) @(posedge clk);
    @(negedge clk);
    check(seqError == 0, "R5", "seqError cleared by reset", seqError, 0);
    snap("R6");

    repeat (4) @(posedge clk);
    check(qPos.size() == 0, "R9", "snapshots outstanding", qPos.size(), 0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule